// File: doc/BRIEF.md
# Receive Packet Checker and FCS Stripper

This block sits after a destuffing stage on the receive side of a packet link. It takes one byte per valid beat, framed by start and end markers, with an optional abort flag from upstream on the end beat. Each packet is counted against a programmable minimum and maximum length. Its frame check sequence is verified as either CRC-16 or CRC-32. The FCS bytes may be dropped and each byte may be bit-reversed. The bytes are then packed into 32-bit words for a receive FIFO. Each word carries start and end flags, a valid-byte count and an abort mark.

The length limits count every byte received, FCS bytes included. An oversize packet ends at once with an aborted closing word, and the rest of it is thrown away until the next start. Two saturating counters record size violations and FCS errors. Packet processing can be switched off as a whole, and FCS processing on its own. Configuration is expected to stay fixed while a packet is open. A start marker is expected only when no packet is open.

Top module: `rx_pkt_checker`

## Requirements
- R1: A byte is taken only on a start beat or while a packet is open. Bytes that arrive outside a packet give no output. Output bytes fill a word from bits [31:24] downward. Non-final words hold 4 bytes and have abort clear. The first word of each packet has out_sop set.
- R2: With packet processing on, a packet whose total length (FCS included) is below cfg_min_len ends aborted, and size_err_cnt goes up by one. A packet of exactly cfg_min_len bytes is not short.
- R3: With packet processing on, the byte numbered cfg_max_len+1 closes the packet at once. The closing word holds the bytes already packed into the open word, or one zero byte if the open word is empty. It has abort set, and size_err_cnt goes up by one. That byte and all later bytes are discarded until the next start. A packet of exactly cfg_max_len bytes is accepted.
- R4: With cfg_fcs32 low, the FCS is CRC-16 with polynomial 0x1021 and an initial value of all ones. Bytes are taken MSB first, and the complement is appended most significant byte first. A mismatch marks the packet aborted and increments fcs_err_cnt.
- R5: With cfg_fcs32 high, the same rule applies with CRC-32 polynomial 0x04C11DB7 and a 4-byte FCS.
- R6: With FCS removal on, the last 2 or 4 bytes of each packet are not output. A packet with no byte left after removal gives one aborted end word with byte count 1 and data zero.
- R7: With FCS removal off, the FCS bytes are output with the packet data.
- R8: With cfg_bit_rev high, each output byte is the bit-reverse of the input byte (input bit 7 becomes output bit 0). The CRC is computed on the bytes as they were received.
- R9: With cfg_pkt_en low, no length or FCS check is made, no byte is removed, and neither counter changes.
- R10: With packet processing on and cfg_fcs_en low, length checks still apply, but the FCS is neither checked nor removed.
- R11: An in_abort flag on the end beat sets out_abort on the packet's end word.
- R12: The end word of a packet appears in the cycle right after the end beat, with out_nbytes between 1 and 4.
- R13: Both error counters saturate at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pkt_en | input | 1 | Packet processing enable |
| cfg_fcs_en | input | 1 | FCS processing enable |
| cfg_fcs32 | input | 1 | 1: CRC-32, 0: CRC-16 |
| cfg_fcs_strip | input | 1 | Remove FCS bytes from output |
| cfg_bit_rev | input | 1 | Reverse bit order in each byte |
| cfg_min_len | input | LEN_W | Minimum packet length in bytes |
| cfg_max_len | input | LEN_W | Maximum packet length in bytes |
| in_valid | input | 1 | Byte beat valid |
| in_sop | input | 1 | First byte of packet |
| in_eop | input | 1 | Last byte of packet |
| in_abort | input | 1 | Upstream abort, read on end beat |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | First word of packet |
| out_eop | output | 1 | Last word of packet |
| out_abort | output | 1 | Packet aborted (on end word) |
| out_data | output | 32 | Packed bytes, first in [31:24] |
| out_nbytes | output | 3 | Valid bytes in word, 1 to 4 |
| size_err_cnt | output | CNT_W | Size violation counter |
| fcs_err_cnt | output | CNT_W | FCS error counter |

## Verification
The bench builds the block with CNT_W set to 3. This makes the counters saturate after seven events, so saturation is reached within a few dozen short packets. LEN_W stays at 16, and the limits are set to 4 and 20 bytes. This places both length boundaries, the oversize cut with a partly filled word, and the zero-byte case after FCS removal within packets of a few bytes. These cases are run under both CRC widths, with removal on and off, and with bit reversal.

// File: rtl/rx_pkt_checker.sv
module rx_pkt_checker #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pkt_en,
  input  logic             cfg_fcs_en,
  input  logic             cfg_fcs32,
  input  logic             cfg_fcs_strip,
  input  logic             cfg_bit_rev,
  input  logic [LEN_W-1:0] cfg_min_len,
  input  logic [LEN_W-1:0] cfg_max_len,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic             in_abort,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_abort,
  output logic [31:0]      out_data,
  output logic [2:0]       out_nbytes,
  output logic [CNT_W-1:0] size_err_cnt,
  output logic [CNT_W-1:0] fcs_err_cnt
);

  localparam logic [31:0] RES16 = 32'h0000_1D0F;
  localparam logic [31:0] RES32 = 32'hC704_DD7B;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d, input logic w32);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = (w32 ? r[31] : r[15]) ^ d[i];
      r  = {r[30:0], 1'b0} ^ (fb ? (w32 ? 32'h04C1_1DB7 : 32'h0000_1021) : 32'h0);
      if (!w32) r[31:16] = 16'h0;
    end
    return r;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  logic             open_q, first_q;
  logic [LEN_W-1:0] len_q;
  logic [31:0]      crc_q, dly_q, acc_q;
  logic [2:0]       dcnt_q;
  logic [1:0]       acnt_q;

  logic             take, fcs_on, oversize, short_pkt, fcs_bad, pop, first_now;
  logic [2:0]       hold, tot;
  logic [LEN_W-1:0] len_nxt;
  logic [31:0]      crc_nxt, acc_ins;
  logic [39:0]      ext;
  logic [7:0]       ob;

  assign take      = in_valid & (in_sop | open_q);
  assign first_now = in_sop | first_q;
  assign fcs_on    = cfg_pkt_en & cfg_fcs_en;
  assign hold      = (fcs_on & cfg_fcs_strip) ? (cfg_fcs32 ? 3'd4 : 3'd2) : 3'd0;
  assign len_nxt   = (&len_q) ? len_q : len_q + 1'b1;
  assign oversize  = cfg_pkt_en & (len_q >= cfg_max_len);
  assign short_pkt = cfg_pkt_en & (len_nxt < cfg_min_len);
  assign crc_nxt   = crc_step(crc_q, in_data, cfg_fcs32);
  assign fcs_bad   = fcs_on & (crc_nxt != (cfg_fcs32 ? RES32 : RES16));
  assign ext       = {dly_q, 8'h00} | ({32'h0, in_data} << (6'd32 - {dcnt_q, 3'b000}));
  assign pop       = dcnt_q >= hold;
  assign ob        = cfg_bit_rev ? rev8(ext[39:32]) : ext[39:32];
  assign acc_ins   = acc_q | ({24'h0, ob} << (6'd24 - {1'b0, acnt_q, 3'b000}));
  assign tot       = {1'b0, acnt_q} + {2'b00, pop};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_sop <= 1'b0; out_eop <= 1'b0; out_abort <= 1'b0;
      out_data <= '0; out_nbytes <= '0;
      size_err_cnt <= '0; fcs_err_cnt <= '0;
      open_q <= 1'b0; first_q <= 1'b0; len_q <= '0; crc_q <= '1;
      dly_q <= '0; dcnt_q <= '0; acc_q <= '0; acnt_q <= '0;
    end else begin
      out_valid <= 1'b0; out_sop <= 1'b0; out_eop <= 1'b0; out_abort <= 1'b0;
      if (take) begin
        if (oversize || in_eop) begin
          out_valid <= 1'b1;
          out_sop   <= first_now;
          out_eop   <= 1'b1;
          if (oversize) begin
            out_abort  <= 1'b1;
            out_data   <= (acnt_q == 2'd0) ? 32'h0 : acc_q;
            out_nbytes <= (acnt_q == 2'd0) ? 3'd1 : {1'b0, acnt_q};
            if (!(&size_err_cnt)) size_err_cnt <= size_err_cnt + 1'b1;
          end else begin
            out_abort  <= in_abort | short_pkt | fcs_bad | (tot == 3'd0);
            out_data   <= (tot == 3'd0) ? 32'h0 : (pop ? acc_ins : acc_q);
            out_nbytes <= (tot == 3'd0) ? 3'd1 : tot;
            if (short_pkt && !(&size_err_cnt)) size_err_cnt <= size_err_cnt + 1'b1;
            if (fcs_bad && !(&fcs_err_cnt)) fcs_err_cnt <= fcs_err_cnt + 1'b1;
          end
          open_q <= 1'b0; first_q <= 1'b0; len_q <= '0; crc_q <= '1;
          dly_q <= '0; dcnt_q <= '0; acc_q <= '0; acnt_q <= '0;
        end else begin
          open_q  <= 1'b1;
          first_q <= first_now;
          len_q   <= len_nxt;
          crc_q   <= crc_nxt;
          dly_q   <= pop ? ext[31:0] : ext[39:8];
          dcnt_q  <= pop ? dcnt_q : dcnt_q + 1'b1;
          if (pop) begin
            if (acnt_q == 2'd3) begin
              out_valid  <= 1'b1;
              out_sop    <= first_now;
              out_data   <= acc_ins;
              out_nbytes <= 3'd4;
              first_q    <= 1'b0;
              acc_q      <= '0;
              acnt_q     <= '0;
            end else begin
              acc_q  <= acc_ins;
              acnt_q <= acnt_q + 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/rx_pkt_checker_sva.sv
module rx_pkt_checker_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_pkt_en,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_eop,
  input logic             out_abort,
  input logic [2:0]       out_nbytes,
  input logic [CNT_W-1:0] size_err_cnt,
  input logic [CNT_W-1:0] fcs_err_cnt
);

  assert_nbytes_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nbytes >= 3'd1 && out_nbytes <= 3'd4));

  assert_word_follows_beat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_mid_word_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eop) |-> (out_nbytes == 3'd4 && !out_abort));

  assert_size_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (size_err_cnt != $past(size_err_cnt)) |->
      (out_valid && out_eop && out_abort && (size_err_cnt - $past(size_err_cnt)) == CNT_W'(1)));

  assert_fcs_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fcs_err_cnt != $past(fcs_err_cnt)) |->
      (out_valid && out_eop && out_abort && (fcs_err_cnt - $past(fcs_err_cnt)) == CNT_W'(1)));

  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_pkt_en) |-> ($stable(size_err_cnt) && $stable(fcs_err_cnt)));

  assert_size_saturates_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(size_err_cnt)) |-> (&size_err_cnt));

  assert_fcs_saturates_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(fcs_err_cnt)) |-> (&fcs_err_cnt));

endmodule

bind rx_pkt_checker rx_pkt_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_pkt_en(cfg_pkt_en), .in_valid(in_valid),
  .out_valid(out_valid), .out_eop(out_eop), .out_abort(out_abort),
  .out_nbytes(out_nbytes), .size_err_cnt(size_err_cnt), .fcs_err_cnt(fcs_err_cnt)
);

// File: tb/rx_pkt_checker_tb.sv
`timescale 1ns/1ps
module rx_pkt_checker_tb;
  localparam int LEN_W = 16;
  localparam int CNT_W = 3;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_pkt_en = 1'b1, cfg_fcs_en = 1'b1, cfg_fcs32 = 1'b0, cfg_fcs_strip = 1'b1, cfg_bit_rev = 1'b0;
  logic [LEN_W-1:0] cfg_min_len = 16'd4, cfg_max_len = 16'd20;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_abort = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_valid, out_sop, out_eop, out_abort;
  logic [31:0] out_data;
  logic [2:0] out_nbytes;
  logic [CNT_W-1:0] size_err_cnt, fcs_err_cnt;

  rx_pkt_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_pkt_en(cfg_pkt_en), .cfg_fcs_en(cfg_fcs_en), .cfg_fcs32(cfg_fcs32),
    .cfg_fcs_strip(cfg_fcs_strip), .cfg_bit_rev(cfg_bit_rev),
    .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_abort(in_abort), .in_data(in_data),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_abort(out_abort),
    .out_data(out_data), .out_nbytes(out_nbytes),
    .size_err_cnt(size_err_cnt), .fcs_err_cnt(fcs_err_cnt)
  );

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R1";
  logic [31:0] eq_data[$];
  logic [2:0]  eq_nb[$];
  logic        eq_sop[$], eq_eop[$], eq_ab[$];
  logic [7:0]  fr[$];
  int size_exp = 0;
  int fcs_exp = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] flip8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  function automatic int sat(input int x);
    return (x > CMAX) ? CMAX : x;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (eq_data.size() == 0) begin
        check(1'b0, "unexpected word", longint'(out_data), 0);
      end else begin
        logic [31:0] d; logic [2:0] nb; logic s, e, a;
        d = eq_data.pop_front(); nb = eq_nb.pop_front();
        s = eq_sop.pop_front(); e = eq_eop.pop_front(); a = eq_ab.pop_front();
        check(out_data == d && out_nbytes == nb && out_sop == s && out_eop == e && out_abort == a,
              "word {sop,eop,abort,nbytes,data}",
              longint'({out_sop, out_eop, out_abort, out_nbytes, out_data}),
              longint'({s, e, a, nb, d}));
      end
    end
  end

  task automatic push_word(input logic [31:0] d, input int nb, input bit s, input bit e, input bit a);
    eq_data.push_back(d); eq_nb.push_back(3'(nb));
    eq_sop.push_back(s); eq_eop.push_back(e); eq_ab.push_back(a);
  endtask

  task automatic send_pkt(input int plen, input int seed, input bit corrupt, input bit upab, input int gap);
    int w, n, hold, k, words;
    bit over, ab, fcs_on;
    logic [31:0] c, fcs, wd;
    fr.delete();
    for (int i = 0; i < plen; i++) fr.push_back(8'((seed * 37 + i * 13 + 5) & 255));
    w = cfg_fcs32 ? 4 : 2;
    c = 32'hFFFF_FFFF;
    if (!cfg_fcs32) c = 32'h0000_FFFF;
    foreach (fr[i]) begin
      for (int b = 7; b >= 0; b--) begin
        bit top;
        top = cfg_fcs32 ? c[31] : c[15];
        c = c << 1;
        if (top ^ fr[i][b]) c = c ^ (cfg_fcs32 ? 32'h04C1_1DB7 : 32'h0000_1021);
        if (!cfg_fcs32) c = c & 32'h0000_FFFF;
      end
    end
    fcs = ~c;
    for (int j = w - 1; j >= 0; j--) fr.push_back(fcs[8*j +: 8]);
    if (corrupt) fr[fr.size()-1] = fr[fr.size()-1] ^ 8'h01;
    n = fr.size();
    fcs_on = cfg_pkt_en && cfg_fcs_en;
    hold = (fcs_on && cfg_fcs_strip) ? w : 0;
    over = cfg_pkt_en && (n > int'(cfg_max_len));
    if (over) k = (int'(cfg_max_len) > hold) ? int'(cfg_max_len) - hold : 0;
    else      k = (n > hold) ? n - hold : 0;
    if (over) begin
      words = k / 4;
      for (int q = 0; q < words; q++) begin
        wd = 0;
        for (int j = 0; j < 4; j++) wd[31-8*j -: 8] = cfg_bit_rev ? flip8(fr[4*q+j]) : fr[4*q+j];
        push_word(wd, 4, q == 0, 1'b0, 1'b0);
      end
      wd = 0;
      for (int j = 0; j < k % 4; j++) wd[31-8*j -: 8] = cfg_bit_rev ? flip8(fr[4*words+j]) : fr[4*words+j];
      push_word(wd, (k % 4 == 0) ? 1 : k % 4, words == 0, 1'b1, 1'b1);
      size_exp++;
    end else begin
      ab = upab || (cfg_pkt_en && n < int'(cfg_min_len)) || (fcs_on && corrupt) || (k == 0);
      if (cfg_pkt_en && n < int'(cfg_min_len)) size_exp++;
      if (fcs_on && corrupt) fcs_exp++;
      if (k == 0) push_word(32'h0, 1, 1'b1, 1'b1, ab);
      else begin
        words = (k + 3) / 4;
        for (int q = 0; q < words; q++) begin
          int nb;
          nb = (q == words - 1) ? k - 4 * q : 4;
          wd = 0;
          for (int j = 0; j < nb; j++) wd[31-8*j -: 8] = cfg_bit_rev ? flip8(fr[4*q+j]) : fr[4*q+j];
          push_word(wd, nb, q == 0, q == words - 1, (q == words - 1) ? ab : 1'b0);
        end
      end
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == n - 1);
      in_abort = upab && (i == n - 1); in_data = fr[i];
      if (i < n - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_abort = 1'b0;
    if (!over) check(out_valid && out_eop, "R12 end word in cycle after end beat", longint'({out_valid, out_eop}), 3);
    @(negedge clk);
    check(int'(size_err_cnt) == sat(size_exp), "size_err_cnt", longint'(size_err_cnt), sat(size_exp));
    check(int'(fcs_err_cnt) == sat(fcs_exp), "fcs_err_cnt", longint'(fcs_err_cnt), sat(fcs_exp));
  endtask

  task automatic stray(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == n - 1); in_data = 8'(i * 29);
    end
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0;
    @(negedge clk);
    check(!out_valid && eq_data.size() == 0, "R1 bytes outside a packet give no word",
          longint'(eq_data.size()), 0);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check(!out_valid && size_err_cnt == 0 && fcs_err_cnt == 0, "reset state",
          longint'({out_valid, size_err_cnt, fcs_err_cnt}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R1";  send_pkt(5, 1, 0, 0, 0); send_pkt(8, 2, 0, 0, 1);
    cur_req = "R2";  send_pkt(1, 3, 0, 0, 0); send_pkt(2, 4, 0, 0, 2);
    cur_req = "R6";  send_pkt(0, 5, 0, 0, 0);
    cur_req = "R4";  send_pkt(6, 6, 1, 0, 0); send_pkt(3, 7, 0, 0, 0);
    cur_req = "R3";  send_pkt(18, 8, 0, 0, 0); send_pkt(25, 9, 0, 0, 0);
    cur_req = "R1";  stray(5); send_pkt(4, 10, 0, 0, 0);

    cfg_fcs32 = 1'b1;
    cur_req = "R5";  send_pkt(7, 11, 0, 0, 0); send_pkt(7, 12, 1, 0, 1);
    cfg_fcs_strip = 1'b0;
    cur_req = "R7";  send_pkt(6, 13, 0, 0, 0);
    cfg_fcs_strip = 1'b1; cfg_bit_rev = 1'b1;
    cur_req = "R8";  send_pkt(9, 14, 0, 0, 0);
    cfg_bit_rev = 1'b0; cfg_fcs32 = 1'b0;
    cur_req = "R11"; send_pkt(5, 15, 0, 1, 0);

    cfg_fcs_en = 1'b0;
    cur_req = "R10"; send_pkt(3, 16, 1, 0, 0); send_pkt(0, 17, 0, 0, 0);
    cfg_fcs_en = 1'b1; cfg_pkt_en = 1'b0;
    cur_req = "R9";  send_pkt(1, 18, 1, 0, 0); send_pkt(30, 19, 0, 0, 0);
    cfg_pkt_en = 1'b1;

    cur_req = "R13";
    for (int i = 0; i < 6; i++) send_pkt(1, 20 + i, 1, 0, 0);
    check(size_err_cnt == 3'd7 && fcs_err_cnt == 3'd7, "R13 both counters saturated",
          longint'({size_err_cnt, fcs_err_cnt}), 6'o77);

    repeat (4) @(negedge clk);
    check(eq_data.size() == 0, "all expected words seen", longint'(eq_data.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule